// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block lets an external host and a local controller CPU exchange commands, parameter bytes and result bytes. The host writes a command byte and queues parameter bytes into a parameter FIFO. The CPU drains those bytes, queues result bytes into a result FIFO, and the host drains them. A busy flag records that a command is pending. The host sets it by writing the command. The CPU releases it. Three interrupt flags carry events the other way. The CPU raises them, the host acknowledges them, and each one can drive a host interrupt line when its enable bit is set.

The CPU sees one 8-bit status word that combines the interrupt flags, the occupancy of both FIFOs and the busy flag. The host sees a smaller status word that carries the same busy flag. Both sides use single-cycle read and write strobes. Read data is combinational from the addressed register or FIFO head, and a pop takes effect at the clock edge that ends the strobe.

Top module: `mbox_hostcpu`

## Requirements
- R1: After a synchronous reset the CPU status word reads 0x60 and both FIFOs are empty. The host status (host address 0) reads 0x00, `h_irq` is low and all interrupt enables are 0.
- R2: With `mode_sel` low, a CPU read at address 7 returns the status word. With `mode_sel` high, that address reads 0x00.
- R3: A CPU write to address 2 with bit k = 1 (k = 0..2) sets interrupt flag k, which appears as status bit k. If the host clears the same flag in the same cycle, the flag stays set.
- R4: A host write to host address 2 with bit k = 1 (k = 0..2) clears interrupt flag k. Flags whose bit is 0 are unchanged.
- R5: Status bit 3 is 1 while the parameter FIFO holds any byte. Host writes to host address 1 push bytes. CPU reads at address 1 return them in arrival order, and each strobed read pops one byte.
- R6: Status bit 4 is 1 when the parameter FIFO holds 8 bytes. A host push while it is full is discarded, so the stored 8 bytes come out unchanged.
- R7: Status bit 5 is 1 while the result FIFO holds fewer than 8 bytes. A CPU write to address 1 while it is full is blocked, and the stored bytes come out unchanged.
- R8: Status bit 6 is 1 while the result FIFO is empty. Host reads at host address 1 return the result bytes in order and pop them. A host read of an empty result FIFO returns 0x00 and changes nothing.
- R9: Status bit 7 is the busy flag. A host write to host address 0 sets it and stores the command byte, which the CPU reads at address 0. A CPU write to address 2 with bit 7 = 1 clears it. If both happen in the same cycle, busy stays set.
- R10: The host status word is {busy, 2'b00, parameter FIFO full, result FIFO not empty, flags[2:0]}. `h_irq` is high exactly when some flag k is set and enable bit k is 1. Enable bits k are written at host address 3, bits 2:0, and read back there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe (pops the result FIFO at address 1) |
| h_addr | input | 2 | Host register address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data |
| h_irq | output | 1 | Host interrupt request |
| mode_sel | input | 1 | Host mode select; status is readable when low |
| c_wr | input | 1 | CPU write strobe |
| c_rd | input | 1 | CPU read strobe (pops the parameter FIFO at address 1) |
| c_addr | input | 3 | CPU register address |
| c_wdata | input | 8 | CPU write data |
| c_rdata | output | 8 | CPU read data |

## Verification
Two pairs of actions can fall in the same cycle: a CPU set and a host clear of the same interrupt flag, and a host command write and a CPU clear-busy write. The bench drives both strobes on the same falling edge so that they land on a single rising edge. It then reads the status word and requires the flag or busy bit to be 1. It also clears a second, untouched flag in that same cycle to confirm that the clear itself took effect. The FIFO full and empty edges are provoked by pushing one byte past capacity and by reading once past empty. Every stored byte is then drained and compared.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   localparam int DW      = 8;
   localparam int NIRQ    = 3;
   localparam int BUSY_BIT = 7;

   // host-side register addresses
   localparam logic [1:0] HA_CMD  = 2'd0;
   localparam logic [1:0] HA_DATA = 2'd1;
   localparam logic [1:0] HA_CTRL = 2'd2;
   localparam logic [1:0] HA_IEN  = 2'd3;

   // CPU-side register addresses
   localparam logic [2:0] CA_CMD  = 3'd0;
   localparam logic [2:0] CA_DATA = 3'd1;
   localparam logic [2:0] CA_CTRL = 3'd2;
   localparam logic [2:0] CA_STAT = 3'd7;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
   parameter int DEPTH = 8,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("mbox_fifo: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("mbox_fifo: W must be positive");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = empty ? '0 : mem[rd_ptr];

   if ((1 << AW) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags #(
   parameter int NIRQ = 3
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NIRQ-1:0] irq_set,
   input  logic [NIRQ-1:0] irq_clr,
   input  logic            busy_set,
   input  logic            busy_clr,
   output logic [NIRQ-1:0] irq_flags,
   output logic            busy
);
   if (NIRQ < 1) begin : g_bad_nirq
      $error("mbox_flags: NIRQ must be positive");
   end

   for (genvar k = 0; k < NIRQ; k++) begin : g_flag
      always_ff @(posedge clk) begin
         if (rst)             irq_flags[k] <= 1'b0;
         else if (irq_set[k]) irq_flags[k] <= 1'b1;
         else if (irq_clr[k]) irq_flags[k] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)           busy <= 1'b0;
      else if (busy_set) busy <= 1'b1;
      else if (busy_clr) busy <= 1'b0;
   end
endmodule

// File: rtl/mbox_hostcpu.sv
module mbox_hostcpu
   import mbox_pkg::*;
#(
   parameter int PAR_DEPTH = 8,
   parameter int RES_DEPTH = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          h_wr,
   input  logic          h_rd,
   input  logic [1:0]    h_addr,
   input  logic [DW-1:0] h_wdata,
   output logic [DW-1:0] h_rdata,
   output logic          h_irq,
   input  logic          mode_sel,
   input  logic          c_wr,
   input  logic          c_rd,
   input  logic [2:0]    c_addr,
   input  logic [DW-1:0] c_wdata,
   output logic [DW-1:0] c_rdata
);
   if (DW != 8) begin : g_bad_dw
      $error("mbox_hostcpu: status layout needs an 8-bit data path");
   end

   // strobe decode
   logic h_cmd_wr, h_par_push, h_ctrl_wr, h_ien_wr, h_res_pop;
   logic c_ctrl_wr, c_res_push, c_par_pop;

   assign h_cmd_wr   = h_wr && (h_addr == HA_CMD);
   assign h_par_push = h_wr && (h_addr == HA_DATA);
   assign h_ctrl_wr  = h_wr && (h_addr == HA_CTRL);
   assign h_ien_wr   = h_wr && (h_addr == HA_IEN);
   assign h_res_pop  = h_rd && (h_addr == HA_DATA);
   assign c_ctrl_wr  = c_wr && (c_addr == CA_CTRL);
   assign c_res_push = c_wr && (c_addr == CA_DATA);
   assign c_par_pop  = c_rd && (c_addr == CA_DATA);

   // parameter and result queues
   logic [DW-1:0] par_head, res_head;
   logic          par_empty, par_full, res_empty, res_full;

   mbox_fifo #(.DEPTH(PAR_DEPTH), .W(DW)) u_par (
      .clk(clk), .rst(rst), .push(h_par_push), .pop(c_par_pop),
      .din(h_wdata), .dout(par_head), .empty(par_empty), .full(par_full));

   mbox_fifo #(.DEPTH(RES_DEPTH), .W(DW)) u_res (
      .clk(clk), .rst(rst), .push(c_res_push), .pop(h_res_pop),
      .din(c_wdata), .dout(res_head), .empty(res_empty), .full(res_full));

   // interrupt and busy handshake
   logic [NIRQ-1:0] irq_flags, irq_set, irq_clr;
   logic            busy;

   assign irq_set = c_ctrl_wr ? c_wdata[NIRQ-1:0] : '0;
   assign irq_clr = h_ctrl_wr ? h_wdata[NIRQ-1:0] : '0;

   mbox_flags #(.NIRQ(NIRQ)) u_flags (
      .clk(clk), .rst(rst), .irq_set(irq_set), .irq_clr(irq_clr),
      .busy_set(h_cmd_wr), .busy_clr(c_ctrl_wr && c_wdata[BUSY_BIT]),
      .irq_flags(irq_flags), .busy(busy));

   // command byte and interrupt enables
   logic [DW-1:0]   cmd_q;
   logic [NIRQ-1:0] ien_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cmd_q <= '0;
         ien_q <= '0;
      end else begin
         if (h_cmd_wr) cmd_q <= h_wdata;
         if (h_ien_wr) ien_q <= h_wdata[NIRQ-1:0];
      end
   end

   assign h_irq = |(irq_flags & ien_q);

   // status words
   logic [DW-1:0] cpu_status, host_status;

   assign cpu_status  = {busy, res_empty, !res_full, par_full, !par_empty, irq_flags};
   assign host_status = {busy, 2'b00, par_full, !res_empty, irq_flags};

   // read muxes
   always_comb begin
      case (h_addr)
         HA_CMD:  h_rdata = host_status;
         HA_DATA: h_rdata = res_head;
         HA_IEN:  h_rdata = {{(DW-NIRQ){1'b0}}, ien_q};
         default: h_rdata = '0;
      endcase
   end

   always_comb begin
      case (c_addr)
         CA_CMD:  c_rdata = cmd_q;
         CA_DATA: c_rdata = par_head;
         CA_STAT: c_rdata = mode_sel ? '0 : cpu_status;
         default: c_rdata = '0;
      endcase
   end
endmodule

// File: rtl/mbox_hostcpu_chk.sv
module mbox_hostcpu_chk (
   input logic       clk,
   input logic       rst,
   input logic       c_ctrl_wr,
   input logic [2:0] c_set_bits,
   input logic       c_busy_bit,
   input logic       h_ctrl_wr,
   input logic [2:0] h_clr_bits,
   input logic [2:0] irq_flags,
   input logic       busy,
   input logic       h_cmd_wr,
   input logic       par_full,
   input logic       h_par_push,
   input logic       c_par_pop,
   input logic       res_full,
   input logic       c_res_push,
   input logic       h_res_pop,
   input logic       h_irq,
   input logic [2:0] ien_q,
   input logic [7:0] cpu_status
);
   p_reset_status_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> cpu_status == 8'h60);

   for (genvar k = 0; k < 3; k++) begin : g_irq
      p_set_wins_r3: assert property (@(posedge clk) disable iff (rst)
         (c_ctrl_wr && c_set_bits[k]) |=> irq_flags[k]);
      p_host_clear_r4: assert property (@(posedge clk) disable iff (rst)
         (h_ctrl_wr && h_clr_bits[k] && !(c_ctrl_wr && c_set_bits[k])) |=> !irq_flags[k]);
   end

   p_par_stays_full_r6: assert property (@(posedge clk) disable iff (rst)
      (par_full && h_par_push && !c_par_pop) |=> par_full);

   p_res_blocked_r7: assert property (@(posedge clk) disable iff (rst)
      (res_full && c_res_push && !h_res_pop) |=> res_full);

   p_busy_set_r9: assert property (@(posedge clk) disable iff (rst)
      h_cmd_wr |=> busy);

   p_busy_clear_r9: assert property (@(posedge clk) disable iff (rst)
      (c_ctrl_wr && c_busy_bit && !h_cmd_wr) |=> !busy);

   p_irq_masked_r10: assert property (@(posedge clk) disable iff (rst)
      (ien_q == 3'b000) |-> !h_irq);
endmodule

bind mbox_hostcpu mbox_hostcpu_chk u_chk (
   .clk(clk), .rst(rst),
   .c_ctrl_wr(c_ctrl_wr), .c_set_bits(c_wdata[2:0]), .c_busy_bit(c_wdata[7]),
   .h_ctrl_wr(h_ctrl_wr), .h_clr_bits(h_wdata[2:0]),
   .irq_flags(irq_flags), .busy(busy), .h_cmd_wr(h_cmd_wr),
   .par_full(par_full), .h_par_push(h_par_push), .c_par_pop(c_par_pop),
   .res_full(res_full), .c_res_push(c_res_push), .h_res_pop(h_res_pop),
   .h_irq(h_irq), .ien_q(ien_q), .cpu_status(cpu_status));

// File: tb/mbox_hostcpu_bench.sv
module mbox_hostcpu_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       h_wr = 1'b0, h_rd = 1'b0;
   logic [1:0] h_addr = 2'd0;
   logic [7:0] h_wdata = 8'h00;
   logic [7:0] h_rdata;
   logic       h_irq;
   logic       mode_sel = 1'b0;
   logic       c_wr = 1'b0, c_rd = 1'b0;
   logic [2:0] c_addr = 3'd7;
   logic [7:0] c_wdata = 8'h00;
   logic [7:0] c_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   mbox_hostcpu u_mbox_hostcpu (
      .clk(clk), .rst(rst), .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr),
      .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq), .mode_sel(mode_sel),
      .c_wr(c_wr), .c_rd(c_rd), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata));

   typedef struct packed {
      logic       hw;
      logic       hr;
      logic [1:0] ha;
      logic [7:0] hd;
      logic       cw;
      logic       cr;
      logic [2:0] ca;
      logic [7:0] cd;
      logic [7:0] exp;
   } vec_t;

   // one-cycle stimulus, then expected CPU status word
   localparam vec_t VECS [9] = '{
      '{1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 3'd2, 8'h05, 8'h65}, // R3 set flags 0,2
      '{1'b1, 1'b0, 2'd2, 8'h01, 1'b0, 1'b0, 3'd7, 8'h00, 8'h64}, // R4 clear flag 0
      '{1'b1, 1'b0, 2'd1, 8'hA1, 1'b0, 1'b0, 3'd7, 8'h00, 8'h6C}, // R5 param push
      '{1'b1, 1'b0, 2'd0, 8'h33, 1'b0, 1'b0, 3'd7, 8'h00, 8'hEC}, // R9 command
      '{1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 3'd1, 8'h5E, 8'hAC}, // R8 result push
      '{1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 3'd2, 8'h80, 8'h2C}, // R9 clear busy
      '{1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 3'd1, 8'h00, 8'h24}, // R5 param pop
      '{1'b0, 1'b1, 2'd1, 8'h00, 1'b0, 1'b0, 3'd7, 8'h00, 8'h64}, // R8 result pop
      '{1'b1, 1'b0, 2'd2, 8'h04, 1'b0, 1'b0, 3'd7, 8'h00, 8'h60}  // R4 clear flag 2
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic idle();
      h_wr = 1'b0; h_rd = 1'b0; c_wr = 1'b0; c_rd = 1'b0;
      h_addr = 2'd0; c_addr = 3'd7;
   endtask

   task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      h_wr = 1'b1; h_addr = a; h_wdata = d;
      @(negedge clk);
      idle();
   endtask

   task automatic cpu_wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      c_wr = 1'b1; c_addr = a; c_wdata = d;
      @(negedge clk);
      idle();
   endtask

   task automatic cpu_pop(output logic [7:0] v);
      @(negedge clk);
      c_rd = 1'b1; c_addr = 3'd1;
      #1 v = c_rdata;
      @(negedge clk);
      idle();
   endtask

   task automatic host_pop(output logic [7:0] v);
      @(negedge clk);
      h_rd = 1'b1; h_addr = 2'd1;
      #1 v = h_rdata;
      @(negedge clk);
      idle();
   endtask

   task automatic status(output logic [7:0] v);
      c_addr = 3'd7;
      #1 v = c_rdata;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1 reset state
      status(v);        check("R1 cpu status", v, 8'h60);
      h_addr = 2'd0; #1 check("R1 host status", h_rdata, 8'h00);
      check("R1 irq", {7'd0, h_irq}, 8'h00);
      h_addr = 2'd3; #1 check("R1 enables", h_rdata, 8'h00);
      idle();

      // table walk
      for (int i = 0; i < 9; i++) begin
         @(negedge clk);
         h_wr = VECS[i].hw; h_rd = VECS[i].hr; h_addr = VECS[i].ha; h_wdata = VECS[i].hd;
         c_wr = VECS[i].cw; c_rd = VECS[i].cr; c_addr = VECS[i].ca; c_wdata = VECS[i].cd;
         @(negedge clk);
         idle();
         status(v);
         check($sformatf("R3/R4/R5/R8/R9 vector %0d", i), v, VECS[i].exp);
      end
      c_addr = 3'd0; #1 check("R9 command byte", c_rdata, 8'h33);
      idle();

      // R2 status hidden in host mode
      mode_sel = 1'b1; status(v); check("R2 mode high", v, 8'h00);
      mode_sel = 1'b0; status(v); check("R2 mode low", v, 8'h60);

      // R6 parameter FIFO full, extra push discarded
      for (int i = 0; i < 9; i++) host_wr(2'd1, 8'h10 + 8'(i));
      status(v); check("R6 full status", v, 8'h78);
      for (int i = 0; i < 8; i++) begin
         cpu_pop(v);
         check($sformatf("R5 R6 param byte %0d", i), v, 8'h10 + 8'(i));
      end
      status(v); check("R5 param drained", v, 8'h60);

      // R7 result FIFO full, extra write blocked
      for (int i = 0; i < 9; i++) cpu_wr(3'd1, 8'h20 + 8'(i));
      status(v); check("R7 full status", v, 8'h00);
      h_addr = 2'd0; #1 check("R10 host status res", h_rdata, 8'h08);
      idle();
      for (int i = 0; i < 8; i++) begin
         host_pop(v);
         check($sformatf("R7 R8 result byte %0d", i), v, 8'h20 + 8'(i));
      end
      host_pop(v); check("R8 empty read data", v, 8'h00);
      status(v);   check("R8 empty read no effect", v, 8'h60);

      // R3 same-cycle set and clear of flag 1; flag 0 cleared alone
      cpu_wr(3'd2, 8'h01);
      @(negedge clk);
      c_wr = 1'b1; c_addr = 3'd2; c_wdata = 8'h02;
      h_wr = 1'b1; h_addr = 2'd2; h_wdata = 8'h03;
      @(negedge clk);
      idle();
      status(v); check("R3 set beats clear", v, 8'h62);

      // R9 same-cycle command and clear busy
      @(negedge clk);
      h_wr = 1'b1; h_addr = 2'd0; h_wdata = 8'h9C;
      c_wr = 1'b1; c_addr = 3'd2; c_wdata = 8'h80;
      @(negedge clk);
      idle();
      status(v); check("R9 set beats clear", v, 8'hE2);
      c_addr = 3'd0; #1 check("R9 command stored", c_rdata, 8'h9C);
      idle();

      // R10 interrupt line and host status
      check("R10 irq masked", {7'd0, h_irq}, 8'h00);
      host_wr(2'd3, 8'h02);
      #1 check("R10 irq enabled", {7'd0, h_irq}, 8'h01);
      h_addr = 2'd3; #1 check("R10 enable readback", h_rdata, 8'h02);
      h_addr = 2'd0; #1 check("R10 host status", h_rdata, 8'h82);
      idle();
      host_wr(2'd3, 8'h05);
      #1 check("R10 other enables", {7'd0, h_irq}, 8'h00);
      host_wr(2'd2, 8'h02);
      status(v); check("R4 flag 1 cleared", v, 8'hE0);

      // R1 reset again from a busy state
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      status(v); check("R1 second reset", v, 8'h60);
      check("R1 irq after reset", {7'd0, h_irq}, 8'h00);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule